// File: doc/BRIEF.md
# Transceiver Channel Reconfiguration Record Streamer

This block lets software change settings on one of several logical transceiver channels through a small set of 32-bit word-addressed registers. Four registers are visible: a channel selector, a control/status word, an offset and a data word. Software first sets up the channel, offset and data. It then writes the control/status word with a start bit and a two-bit mode. While the operation runs, software polls a busy flag.

The block has two modes. In direct mode, one 16-bit record goes to the selected channel at the programmed offset. In stream mode, the offset/data pair acts as an indirect internal register pair. Internal offset 0 takes the base address of a record image. Internal offset 1 with the command value 3 starts an autonomous walk through an attached synchronous record memory. Each 32-bit memory word carries a 16-bit data value and a 12-bit target offset, and each word is sent to the channel in turn until an all-ones end marker is read.

Each channel write is a single-cycle strobe carrying channel, offset and data. The block then waits for an acknowledge before it does anything else.

Top module: `recfg_streamer`

## Requirements
- R1: After reset, all four registers read zero, the busy bit (control/status bit 8) and the error bit (bit 9) are zero, and no channel strobe or memory read is issued.
- R2: Registers sit at word addresses 0x38 (channel), 0x3A (control/status), 0x3B (offset, 12 bits) and 0x3C (data, 32 bits). While idle, each reads back what was written. Control/status bits [3:2] hold the mode, and bit 0 (start) always reads 0.
- R3: A control/status write with bit 0 set while idle starts an operation. Busy reads 1 on the first read issued after that write, and stays 1 until the operation ends.
- R4: With mode 2'b01 (direct), one channel strobe is issued. It carries the channel register, the offset register and data bits [15:0]. Busy clears after the acknowledge.
- R5: With mode 2'b00 (stream) and offset 0, a start loads the data register as the record image base address and makes no channel write.
- R6: With mode 2'b00, offset 1 and data 3, a start reads memory words upward from the base. Each word gives one strobe, with data from bits [15:0] and offset from bits [27:16], in address order. The walk stops at the word 0xFFFFFFFF, which is not sent, and busy then clears.
- R7: Only one channel write is outstanding at a time. The next memory read is issued only after the previous strobe has been acknowledged.
- R8: While busy, writes to the channel, offset, data and control/status registers are ignored, and a start request is dropped.
- R9: If the channel register is not below the configured channel count at start, the error bit is set, no channel write occurs, and busy clears. The next start with a valid channel clears the error bit.
- R10: In stream mode, a start with offset 1 and data other than 3, or with an offset above 1, performs no channel write and completes.
- R11: The channel strobe is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable; data is returned on the next cycle |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mem_rd | output | 1 | Record memory read request |
| mem_addr | output | MAW | Record memory word address |
| mem_rdata | input | 32 | Record memory data, valid the cycle after the request is sampled |
| ch_stb | output | 1 | Channel write strobe, one cycle |
| ch_sel | output | $clog2(NUM_CH) | Target logical channel |
| ch_offset | output | 12 | Target setting offset |
| ch_data | output | 16 | Setting value |
| ch_ack | input | 1 | Channel write acknowledge |

## Verification
The assertions check these properties on every cycle. The strobe is a single-cycle pulse. At most one channel write is outstanding, and no memory read is issued while a write is unacknowledged. An accepted start raises busy at once. A start with a bad channel produces no strobe. Registers hold their values while busy. Other behaviour can only be shown by the bench scenarios, because it depends on data and order. This covers the record fields and their order across a memory walk, stopping at the end marker, the base address load, the ignored stream commands, and the clearing of the error bit by a later valid start.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam logic [7:0] A_CHAN = 8'h38;
  localparam logic [7:0] A_CSR  = 8'h3A;
  localparam logic [7:0] A_OFFS = 8'h3B;
  localparam logic [7:0] A_DATA = 8'h3C;

  localparam int CSR_START = 0;
  localparam int CSR_MODE_LO = 2;
  localparam int CSR_BUSY = 8;
  localparam int CSR_ERR = 9;

  localparam int OFFS_W = 12;
  localparam int REC_W  = 16;
  localparam int REC_OFF_LO = 16;

  localparam logic [31:0] END_WORD   = 32'hFFFF_FFFF;
  localparam logic [31:0] LAUNCH_CMD = 32'h3;

  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_RSV2   = 2'b10,
    MODE_RSV3   = 2'b11
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_MREQ,
    ST_MDATA,
    ST_FIN
  } eng_st_t;
endpackage

// File: rtl/recfg_regs.sv
module recfg_regs
  import recfg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CH_REG_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                busy,
  input  logic                err,
  output logic [CH_REG_W-1:0] chan_q,
  output logic [OFFS_W-1:0]   offs_q,
  output logic [31:0]         data_q,
  output logic                go,
  output mode_t               go_mode
);
  mode_t mode_q;
  logic  wr_ok;

  assign wr_ok   = bus_wr && !busy;
  assign go      = wr_ok && (bus_addr == ADDR_W'(A_CSR)) && bus_wdata[CSR_START];
  assign go_mode = mode_t'(bus_wdata[CSR_MODE_LO +: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      offs_q <= '0;
      data_q <= '0;
      mode_q <= MODE_STREAM;
    end else if (wr_ok) begin
      case (bus_addr)
        ADDR_W'(A_CHAN): chan_q <= bus_wdata[CH_REG_W-1:0];
        ADDR_W'(A_CSR):  mode_q <= mode_t'(bus_wdata[CSR_MODE_LO +: 2]);
        ADDR_W'(A_OFFS): offs_q <= bus_wdata[OFFS_W-1:0];
        ADDR_W'(A_DATA): data_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  logic [31:0] csr_view;
  always_comb begin
    csr_view = '0;
    csr_view[CSR_MODE_LO +: 2] = mode_q;
    csr_view[CSR_BUSY] = busy;
    csr_view[CSR_ERR]  = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CHAN): bus_rdata <= 32'(chan_q);
        ADDR_W'(A_CSR):  bus_rdata <= csr_view;
        ADDR_W'(A_OFFS): bus_rdata <= 32'(offs_q);
        ADDR_W'(A_DATA): bus_rdata <= data_q;
        default:         bus_rdata <= '0;
      endcase
    end
  end

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(chan_q) && $stable(offs_q) && $stable(data_q) && $stable(mode_q)));
endmodule

// File: rtl/recfg_engine.sv
module recfg_engine
  import recfg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_REG_W = 8,
  parameter int MAW      = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  mode_t               go_mode,
  input  logic [CH_REG_W-1:0] chan_q,
  input  logic [OFFS_W-1:0]   offs_q,
  input  logic [31:0]         data_q,
  output logic                busy,
  output logic                err,
  output logic                send,
  output logic [OFFS_W-1:0]   snd_off,
  output logic [REC_W-1:0]    snd_data,
  input  logic                port_pending,
  input  logic                port_done,
  output logic                mem_rd,
  output logic [MAW-1:0]      mem_addr,
  input  logic [31:0]         mem_rdata
);
  eng_st_t        st;
  logic [MAW-1:0] base_q;
  logic [MAW-1:0] ptr_q;
  logic           streaming;
  logic           chan_bad;

  assign chan_bad = (chan_q >= CH_REG_W'(NUM_CH));
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      err       <= 1'b0;
      base_q    <= '0;
      ptr_q     <= '0;
      streaming <= 1'b0;
      send      <= 1'b0;
      snd_off   <= '0;
      snd_data  <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      send   <= 1'b0;
      mem_rd <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          if (chan_bad) begin
            err <= 1'b1;
            st  <= ST_FIN;
          end else begin
            err <= 1'b0;
            case (go_mode)
              MODE_DIRECT: begin
                send      <= 1'b1;
                snd_off   <= offs_q;
                snd_data  <= data_q[REC_W-1:0];
                streaming <= 1'b0;
                st        <= ST_ACK;
              end
              MODE_STREAM: begin
                if (offs_q == '0) begin
                  base_q <= data_q[MAW-1:0];
                  st     <= ST_FIN;
                end else if (offs_q == OFFS_W'(1) && data_q == LAUNCH_CMD) begin
                  mem_rd    <= 1'b1;
                  mem_addr  <= base_q;
                  ptr_q     <= base_q + MAW'(1);
                  streaming <= 1'b1;
                  st        <= ST_MREQ;
                end else begin
                  st <= ST_FIN;
                end
              end
              default: st <= ST_FIN;
            endcase
          end
        end
        ST_MREQ: st <= ST_MDATA;
        ST_MDATA: begin
          if (mem_rdata == END_WORD) begin
            st <= ST_FIN;
          end else begin
            send     <= 1'b1;
            snd_off  <= mem_rdata[REC_OFF_LO +: OFFS_W];
            snd_data <= mem_rdata[REC_W-1:0];
            st       <= ST_ACK;
          end
        end
        ST_ACK: if (port_done) begin
          if (streaming) begin
            mem_rd   <= 1'b1;
            mem_addr <= ptr_q;
            ptr_q    <= ptr_q + MAW'(1);
            st       <= ST_MREQ;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
  assert_bad_chan_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (go && chan_bad) |=> (err && !send));
  assert_fetch_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !port_pending);
endmodule

// File: rtl/recfg_chan_port.sv
module recfg_chan_port
  import recfg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_REG_W = 8,
  localparam int CSW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                send,
  input  logic [CH_REG_W-1:0] chan_in,
  input  logic [OFFS_W-1:0]   off_in,
  input  logic [REC_W-1:0]    data_in,
  output logic                ch_stb,
  output logic [CSW-1:0]      ch_sel,
  output logic [OFFS_W-1:0]   ch_offset,
  output logic [REC_W-1:0]    ch_data,
  input  logic                ch_ack,
  output logic                pending,
  output logic                done
);
  assign done = pending && ch_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_stb    <= 1'b0;
      ch_sel    <= '0;
      ch_offset <= '0;
      ch_data   <= '0;
      pending   <= 1'b0;
    end else begin
      ch_stb <= send;
      if (send) begin
        ch_sel    <= chan_in[CSW-1:0];
        ch_offset <= off_in;
        ch_data   <= data_in;
        pending   <= 1'b1;
      end else if (done) begin
        pending <= 1'b0;
      end
    end
  end

  assert_stb_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    ch_stb |=> !ch_stb);
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    send |-> !pending);
endmodule

// File: rtl/recfg_streamer.sv
module recfg_streamer
  import recfg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_REG_W = 8,
  parameter int ADDR_W   = 8,
  parameter int MAW      = 10,
  localparam int CSW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mem_rd,
  output logic [MAW-1:0]    mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              ch_stb,
  output logic [CSW-1:0]    ch_sel,
  output logic [11:0]       ch_offset,
  output logic [15:0]       ch_data,
  input  logic              ch_ack
);
  logic [CH_REG_W-1:0] chan_q;
  logic [OFFS_W-1:0]   offs_q;
  logic [31:0]         data_q;
  logic                go, busy, err;
  mode_t               go_mode;
  logic                send, pending, done;
  logic [OFFS_W-1:0]   snd_off;
  logic [REC_W-1:0]    snd_data;

  recfg_regs #(.ADDR_W(ADDR_W), .CH_REG_W(CH_REG_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .err(err), .chan_q(chan_q), .offs_q(offs_q),
    .data_q(data_q), .go(go), .go_mode(go_mode)
  );

  recfg_engine #(.NUM_CH(NUM_CH), .CH_REG_W(CH_REG_W), .MAW(MAW)) u_engine (
    .clk(clk), .rst(rst), .go(go), .go_mode(go_mode), .chan_q(chan_q),
    .offs_q(offs_q), .data_q(data_q), .busy(busy), .err(err),
    .send(send), .snd_off(snd_off), .snd_data(snd_data),
    .port_pending(pending), .port_done(done),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  recfg_chan_port #(.NUM_CH(NUM_CH), .CH_REG_W(CH_REG_W)) u_port (
    .clk(clk), .rst(rst), .send(send), .chan_in(chan_q),
    .off_in(snd_off), .data_in(snd_data),
    .ch_stb(ch_stb), .ch_sel(ch_sel), .ch_offset(ch_offset),
    .ch_data(ch_data), .ch_ack(ch_ack), .pending(pending), .done(done)
  );
endmodule

// File: tb/recfg_streamer_test.sv
`timescale 1ns/1ps
module recfg_streamer_test;
  localparam int NUM_CH = 4;
  localparam int MAW    = 10;
  localparam int CSW    = 2;
  localparam real HALF  = 2.5;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mem_rd; logic [MAW-1:0] mem_addr; logic [31:0] mem_rdata;
  logic ch_stb; logic [CSW-1:0] ch_sel; logic [11:0] ch_offset; logic [15:0] ch_data;
  logic ch_ack;

  always #(HALF) clk = ~clk;

  recfg_streamer #(.NUM_CH(NUM_CH), .MAW(MAW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ch_stb(ch_stb),
    .ch_sel(ch_sel), .ch_offset(ch_offset), .ch_data(ch_data), .ch_ack(ch_ack)
  );

  logic [31:0] mem [1024];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int ack_delay = 0;
  int cnt = 0;
  logic waiting = 0;
  int rec_n = 0;
  int r7_viol = 0;
  logic [31:0] rec_ch [64], rec_off [64], rec_dat [64];

  always_ff @(posedge clk) begin
    ch_ack <= 1'b0;
    if (rst) begin
      waiting <= 1'b0;
    end else begin
      if (mem_rd && waiting) r7_viol <= r7_viol + 1;
      if (ch_stb) begin
        if (rec_n < 64) begin
          rec_ch[rec_n]  <= 32'(ch_sel);
          rec_off[rec_n] <= 32'(ch_offset);
          rec_dat[rec_n] <= 32'(ch_data);
        end
        rec_n   <= rec_n + 1;
        cnt     <= ack_delay;
        waiting <= 1'b1;
      end else if (waiting) begin
        if (cnt == 0) begin ch_ack <= 1'b1; waiting <= 1'b0; end
        else cnt <= cnt - 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] csr);
    for (int i = 0; i < 2000; i++) begin
      rd(8'h3A, csr);
      if (!csr[8]) return;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h38, d); check("R1 chan", d, 0);
    rd(8'h3A, d); check("R1 csr", d, 0);
    rd(8'h3B, d); check("R1 offs", d, 0);
    rd(8'h3C, d); check("R1 data", d, 0);
    check("R1 no strobe", 32'(rec_n), 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(8'h38, 32'h2); wr(8'h3B, 32'h7); wr(8'h3C, 32'h1234ABCD); wr(8'h3A, 32'h4);
    rd(8'h38, d); check("R2 chan", d, 32'h2);
    rd(8'h3B, d); check("R2 offs", d, 32'h7);
    rd(8'h3C, d); check("R2 data", d, 32'h1234ABCD);
    rd(8'h3A, d); check("R2 csr mode", d, 32'h4);
    wr(8'h3B, 32'hFFFF_F123);
    rd(8'h3B, d); check("R2 offs width", d, 32'h123);
  endtask

  task automatic t_direct;
    logic [31:0] d; int base_n;
    base_n = rec_n; ack_delay = 5;
    wr(8'h38, 32'h1); wr(8'h3B, 32'h2A); wr(8'h3C, 32'h0000BEEF);
    wr(8'h3A, 32'h5);
    rd(8'h3A, d); check("R3 busy set", 32'(d[8]), 1);
    check("R2 start reads 0", 32'(d[0]), 0);
    wait_idle(d); check("R4 busy clears", 32'(d[8]), 0);
    check("R4 one strobe", 32'(rec_n - base_n), 1);
    check("R4 chan", rec_ch[base_n], 1);
    check("R4 offset", rec_off[base_n], 32'h2A);
    check("R4 data", rec_dat[base_n], 32'hBEEF);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d; int base_n;
    base_n = rec_n; ack_delay = 30;
    wr(8'h38, 32'h0); wr(8'h3B, 32'h11); wr(8'h3C, 32'h2222);
    wr(8'h3A, 32'h5);
    wr(8'h38, 32'h3); wr(8'h3B, 32'h9); wr(8'h3C, 32'h55); wr(8'h3A, 32'h1);
    wait_idle(d);
    check("R8 mode kept", 32'(d[3:2]), 1);
    rd(8'h38, d); check("R8 chan kept", d, 0);
    rd(8'h3B, d); check("R8 offs kept", d, 32'h11);
    rd(8'h3C, d); check("R8 data kept", d, 32'h2222);
    repeat (40) @(negedge clk);
    check("R8 start dropped", 32'(rec_n - base_n), 1);
    ack_delay = 0;
  endtask

  task automatic t_stream;
    logic [31:0] d; int base_n;
    for (int i = 0; i < 3; i++)
      mem[10'h100 + i] = {4'h0, 12'(12'h10 + i), 16'(16'hA000 + 16'(i * 7))};
    mem[10'h103] = 32'hFFFF_FFFF;
    mem[10'h200] = 32'hFFFF_FFFF;
    base_n = rec_n; ack_delay = 3;
    wr(8'h38, 32'h2); wr(8'h3A, 32'h0);
    wr(8'h3B, 32'h0); wr(8'h3C, 32'h100); wr(8'h3A, 32'h1);
    wait_idle(d);
    check("R5 base load no write", 32'(rec_n - base_n), 0);
    wr(8'h3B, 32'h1); wr(8'h3C, 32'h3); wr(8'h3A, 32'h1);
    rd(8'h3A, d); check("R3 busy in stream", 32'(d[8]), 1);
    wait_idle(d);
    check("R6 record count", 32'(rec_n - base_n), 3);
    for (int i = 0; i < 3; i++) begin
      check("R6 chan", rec_ch[base_n + i], 2);
      check("R6 offset", rec_off[base_n + i], 32'h10 + i);
      check("R6 data", rec_dat[base_n + i], 32'hA000 + i * 7);
    end
    check("R7 fetch after ack", 32'(r7_viol), 0);
    ack_delay = 0; base_n = rec_n;
    wr(8'h3B, 32'h0); wr(8'h3C, 32'h200); wr(8'h3A, 32'h1); wait_idle(d);
    wr(8'h3B, 32'h1); wr(8'h3C, 32'h3); wr(8'h3A, 32'h1); wait_idle(d);
    check("R6 empty image", 32'(rec_n - base_n), 0);
    check("R6 busy clears", 32'(d[8]), 0);
  endtask

  task automatic t_bad_cmd;
    logic [31:0] d; int base_n;
    base_n = rec_n;
    wr(8'h3B, 32'h0); wr(8'h3C, 32'h100); wr(8'h3A, 32'h1); wait_idle(d);
    wr(8'h3B, 32'h1); wr(8'h3C, 32'h2); wr(8'h3A, 32'h1); wait_idle(d);
    check("R10 data not 3", 32'(rec_n - base_n), 0);
    wr(8'h3B, 32'h2); wr(8'h3C, 32'h3); wr(8'h3A, 32'h1); wait_idle(d);
    check("R10 offset 2", 32'(rec_n - base_n), 0);
    check("R10 completes", 32'(d[8]), 0);
  endtask

  task automatic t_bad_chan;
    logic [31:0] d; int base_n;
    base_n = rec_n;
    wr(8'h38, 32'h7); wr(8'h3B, 32'h5); wr(8'h3C, 32'h77); wr(8'h3A, 32'h5);
    wait_idle(d);
    check("R9 err set", 32'(d[9]), 1);
    check("R9 no write", 32'(rec_n - base_n), 0);
    wr(8'h38, 32'h4); wr(8'h3B, 32'h1); wr(8'h3C, 32'h3); wr(8'h3A, 32'h1);
    wait_idle(d);
    check("R9 stream no write", 32'(rec_n - base_n), 0);
    check("R9 err kept", 32'(d[9]), 1);
    wr(8'h38, 32'h3); wr(8'h3B, 32'h6); wr(8'h3C, 32'h1357); wr(8'h3A, 32'h5);
    wait_idle(d);
    check("R9 err cleared", 32'(d[9]), 0);
    check("R9 valid write", 32'(rec_n - base_n), 1);
    check("R9 last chan", rec_ch[base_n], 3);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset;
    t_readback;
    t_direct;
    t_busy_ignore;
    t_stream;
    t_bad_cmd;
    t_bad_chan;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 2 * HALF);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule